// File: doc/BRIEF.md
# Interrupt Pin Redirection Service Engine

The engine takes 24 interrupt request inputs and routes each one through a 64-bit redirection entry. That entry holds the vector, the delivery mode, the destination, the trigger mode and a mask. Each pin has a pending bit. The pending bit follows edge or level semantics. Level pins also carry a remote-pending flag: it blocks a second delivery until an end-of-interrupt (EOI) carrying the pin's vector is received.

Every delivery becomes a memory-write style message. The message is a 32-bit address and a 32-bit data word, offered on a valid/ready port. Pins are served one at a time, lowest index first.

Entries are written and read through a 32-bit register-file port, one half-entry at a time. Entry writes, input activity, EOIs and the rescan input each start a service pass. A pass runs until no pin can be delivered.

Entry layout used by every requirement below:

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery mode |
| 11 | destination mode |
| 12 | delivery status, always 0 |
| 13 | polarity, stored only |
| 14 | remote-pending |
| 15 | trigger, 1 = level |
| 16 | mask |
| 63:56 | destination |

Top module: `irq_redir_engine`

## Requirements
- R1: After reset, every entry reads back 0x00010000 in its low half and 0 in its high half, so it is masked with all other fields zero. No pin is pending and `msg_valid_o` is low.
- R2: Input 0 drives pin 2. Input 2 also drives pin 2, and every other input k drives pin k. Pin 0 is never driven, so input 0 never produces pin 0's vector.
- R3: On an edge pin, a rising input sets the pending bit only when the entry is unmasked. A rising input on a masked edge pin is dropped, and a later unmask delivers nothing.
- R4: On a level pin, a high input sets the pending bit whatever the mask, and a low input clears it. A masked level pin that is still high is delivered once it is unmasked.
- R5: Deliverable pins are sent in ascending pin order, one message each, and masked pins are skipped.
- R6: An edge pin's pending bit clears when its message is loaded, so one rising edge gives exactly one message.
- R7: Delivering a level pin sets its remote-pending bit (entry bit 14). While that bit is set, the pin is not delivered again, even if its input stays high.
- R8: An EOI clears remote-pending on every level entry whose vector matches the EOI vector. If such a pin is still pending and unmasked, it is delivered again.
- R9: Entry writes do not change bits 12 and 14. A write that leaves the entry in edge mode (bit 15 = 0) clears bit 14.
- R10: The message address is 0xFEE00000 with the destination in bits 19:12 and the destination-mode bit in bit 2. For example, destination 2 gives 0xFEE02000.
- R11: The message data has the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger bit in bit 15. For example, a level entry with vector 0x21 gives 0x00008021.
- R12: While `msg_valid_o` is high and `msg_ready_i` is low, valid, address and data stay unchanged. At most one message is outstanding at a time.
- R13: A pulse on `rescan_i` starts a service pass. When nothing is deliverable, the pass produces no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 24 | Interrupt request input levels |
| cfg_we_i | input | 1 | Write strobe for the half-entry |
| cfg_idx_i | input | 5 | Entry index for write and readback |
| cfg_hi_i | input | 1 | Half select: 1 selects bits 63:32, 0 selects bits 31:0 |
| cfg_wdata_i | input | 32 | Half-entry write data |
| cfg_rdata_o | output | 32 | Selected half-entry readback, combinational |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector carried by the EOI |
| rescan_i | input | 1 | Request a service pass |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Message accepted while valid |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
A remote-pending bit stuck high on a level pin shows up as a missing redelivery after an EOI, within two cycles. The same bit is visible as bit 14 on readback. A pending bit left set after an edge delivery shows up as a duplicate message right after the first one is accepted. A bad priority pick sends a higher pin first when two edges arrive together. A stale pending bit on a masked edge pin leaks out as a message once the pin is unmasked.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int ENT_W = 64;
  localparam int F_DLV_LO = 8;
  localparam int F_DMODE = 11;
  localparam int F_DSTAT = 12;
  localparam int F_RIRR = 14;
  localparam int F_TRIG = 15;
  localparam int F_MASK = 16;
  localparam int F_DEST_LO = 56;
  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

  function automatic logic [31:0] msg_addr(input logic [ENT_W-1:0] e);
    return {12'hFEE, e[F_DEST_LO+7:F_DEST_LO], 9'b0, e[F_DMODE], 2'b0};
  endfunction

  function automatic logic [31:0] msg_data(input logic [ENT_W-1:0] e);
    return {16'h0, e[F_TRIG], 4'h0, e[F_DLV_LO+2:F_DLV_LO], e[7:0]};
  endfunction
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            hi_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  input  logic                            grant_i,
  input  logic [IDX_W-1:0]                grant_idx_i,
  input  logic                            eoi_i,
  input  logic [7:0]                      eoi_vec_i,
  output logic [NUM_PINS-1:0][ENT_W-1:0]  ent_o
);
  logic [NUM_PINS-1:0][ENT_W-1:0] ent_q, ent_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    always_comb begin
      logic [ENT_W-1:0] m;
      m = ent_q[i];
      if (we_i && idx_i == IDX_W'(i)) begin
        m = hi_i ? {wdata_i, ent_q[i][31:0]} : {ent_q[i][63:32], wdata_i};
        m[F_DSTAT] = ent_q[i][F_DSTAT];
        m[F_RIRR]  = ent_q[i][F_RIRR];
        if (!m[F_TRIG]) m[F_RIRR] = 1'b0;
      end
      if (grant_i && grant_idx_i == IDX_W'(i) && m[F_TRIG]) m[F_RIRR] = 1'b1;
      if (eoi_i && ent_q[i][F_TRIG] && ent_q[i][7:0] == eoi_vec_i) m[F_RIRR] = 1'b0;
      ent_d[i] = m;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[i] <= ENT_RESET;
      else         ent_q[i] <= ent_d[i];
    end

    // R9: edge entries never keep remote-pending
    a_r9_edge_no_rirr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ent_q[i][F_TRIG] |-> !ent_q[i][F_RIRR]);
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (idx_i == IDX_W'(i)) rdata_o = hi_i ? ent_q[i][63:32] : ent_q[i][31:0];
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/irq_redir_pend.sv
module irq_redir_pend #(
  parameter int NUM_PINS = 24,
  parameter int ALIAS_SRC = 0,
  parameter int ALIAS_DST = 2,
  parameter int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic [NUM_PINS-1:0] irr_o,
  output logic                rise_o
);
  logic [NUM_PINS-1:0] pin_lvl, prev_q, irr_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == ALIAS_SRC) begin : g_dead
      assign pin_lvl[i] = 1'b0;
    end else if (i == ALIAS_DST) begin : g_alias
      assign pin_lvl[i] = irq_i[i] | irq_i[ALIAS_SRC];
    end else begin : g_direct
      assign pin_lvl[i] = irq_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i] <= 1'b0;
        irr_q[i]  <= 1'b0;
      end else begin
        prev_q[i] <= pin_lvl[i];
        if (trig_i[i])                                 irr_q[i] <= pin_lvl[i];
        else if (pin_lvl[i] && !prev_q[i] && !mask_i[i]) irr_q[i] <= 1'b1;
        else if (clr_i && clr_idx_i == IDX_W'(i))      irr_q[i] <= 1'b0;
      end
    end

    a_r3_masked_edge_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irr_q[i] && !trig_i[i] && mask_i[i]) |=> !irr_q[i]);
    a_r4_level_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[i] && !pin_lvl[i]) |=> !irr_q[i]);
  end

  assign irr_o  = irr_q;
  assign rise_o = |(pin_lvl & ~prev_q);
endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PINS-1:0]            irr_i,
  input  logic [NUM_PINS-1:0][ENT_W-1:0] ent_i,
  input  logic                           kick_i,
  output logic                           grant_o,
  output logic [IDX_W-1:0]               grant_idx_o,
  output logic                           msg_valid_o,
  input  logic                           msg_ready_i,
  output logic [31:0]                    msg_addr_o,
  output logic [31:0]                    msg_data_o
);
  logic [NUM_PINS-1:0] elig;
  logic [IDX_W-1:0]    pick;
  logic [ENT_W-1:0]    sel;
  logic                sweep_q, load;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_elig
    assign elig[i] = irr_i[i] && !ent_i[i][F_MASK] &&
                     (!ent_i[i][F_TRIG] || !ent_i[i][F_RIRR]);
  end

  always_comb begin
    pick = '0;
    sel  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (elig[i]) begin
        pick = IDX_W'(i);
        sel  = ent_i[i];
      end
  end

  assign load        = sweep_q && !msg_valid_o && |elig;
  assign grant_o     = load;
  assign grant_idx_o = pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q     <= 1'b0;
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else begin
      if (kick_i)                                  sweep_q <= 1'b1;
      else if (sweep_q && !msg_valid_o && !(|elig)) sweep_q <= 1'b0;
      if (load) begin
        msg_valid_o <= 1'b1;
        msg_addr_o  <= msg_addr(sel);
        msg_data_o  <= msg_data(sel);
      end else if (msg_ready_i) begin
        msg_valid_o <= 1'b0;
      end
    end
  end

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic                cfg_hi_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i,
  input  logic                rescan_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o
);
  logic [NUM_PINS-1:0][ENT_W-1:0] ent;
  logic [NUM_PINS-1:0]            trig, mask, irr;
  logic                           grant, rise, kick;
  logic [IDX_W-1:0]               grant_idx;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fld
    assign trig[i] = ent[i][F_TRIG];
    assign mask[i] = ent[i][F_MASK];
  end

  assign kick = rise | cfg_we_i | eoi_valid_i | rescan_i;

  irq_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .hi_i(cfg_hi_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .grant_i(grant), .grant_idx_i(grant_idx),
    .eoi_i(eoi_valid_i), .eoi_vec_i(eoi_vector_i),
    .ent_o(ent)
  );

  irq_redir_pend #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pend (
    .clk_i, .rst_ni, .irq_i,
    .trig_i(trig), .mask_i(mask),
    .clr_i(grant), .clr_idx_i(grant_idx),
    .irr_o(irr), .rise_o(rise)
  );

  irq_redir_arb #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_arb (
    .clk_i, .rst_ni,
    .irr_i(irr), .ent_i(ent), .kick_i(kick),
    .grant_o(grant), .grant_idx_o(grant_idx),
    .msg_valid_o, .msg_ready_i, .msg_addr_o, .msg_data_o
  );
endmodule

// File: tb/irq_redir_engine_test.sv
module irq_redir_engine_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] irq = '0;
  logic        we = 0, hi = 0, eoi = 0, rescan = 0, ready = 0;
  logic [4:0]  idx = '0;
  logic [31:0] wdata = '0, rdata, maddr, mdata;
  logic [7:0]  eoi_vec = '0;
  logic        mvalid;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  irq_redir_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .cfg_we_i(we), .cfg_idx_i(idx), .cfg_hi_i(hi), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .eoi_valid_i(eoi), .eoi_vector_i(eoi_vec),
    .rescan_i(rescan), .msg_valid_o(mvalid), .msg_ready_i(ready),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  typedef struct packed {
    logic [4:0] pin;
    logic [7:0] vec;
    logic [2:0] dlv;
    logic       dm;
    logic [7:0] dest;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{5'd1,  8'h31, 3'd0, 1'b0, 8'h02},
    '{5'd5,  8'h45, 3'd1, 1'b1, 8'h0f},
    '{5'd23, 8'hfe, 3'd4, 1'b0, 8'hff},
    '{5'd10, 8'h10, 3'd7, 1'b1, 8'h80},
    '{5'd17, 8'h99, 3'd2, 1'b0, 8'h00},
    '{5'd2,  8'h22, 3'd5, 1'b1, 8'h5a}
  };

  function automatic logic [31:0] exp_addr(logic [7:0] d, logic m);
    return 32'hFEE0_0000 | (32'(d) << 12) | (32'(m) << 2);
  endfunction
  function automatic logic [31:0] exp_data(logic [7:0] v, logic [2:0] dl, logic lv);
    return 32'(v) | (32'(dl) << 8) | (32'(lv) << 15);
  endfunction
  function automatic logic [31:0] lo_word(logic [7:0] v, logic [2:0] dl, logic m,
                                          logic lv, logic mk);
    return 32'(v) | (32'(dl) << 8) | (32'(m) << 11) | (32'(lv) << 15) | (32'(mk) << 16);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input bit h, input logic [31:0] d);
    @(negedge clk); we = 1; idx = 5'(p); hi = h; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int p, input bit h, output logic [31:0] v);
    @(negedge clk); idx = 5'(p); hi = h; #1 v = rdata;
  endtask

  task automatic pulse(input int p);
    @(negedge clk); irq[p] = 1;
    @(negedge clk); irq[p] = 0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk); eoi = 1; eoi_vec = v;
    @(negedge clk); eoi = 0;
  endtask

  task automatic take(input logic [31:0] ea, ed, input string req);
    int n = 0;
    @(negedge clk);
    while (!mvalid && n < 30) begin @(negedge clk); n++; end
    chk(mvalid, req, {31'b0, mvalid}, 32'h1);
    chk(maddr == ea, req, maddr, ea);
    chk(mdata == ed, req, mdata, ed);
    ready = 1; @(negedge clk); ready = 0;
  endtask

  task automatic none(input int cyc, input string req);
    bit seen = 0;
    for (int k = 0; k < cyc; k++) begin @(negedge clk); if (mvalid) seen = 1; end
    chk(!seen, req, {31'b0, seen}, 32'h0);
    if (mvalid) begin ready = 1; @(negedge clk); ready = 0; end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5, 0, v); chk(v == 32'h0001_0000, "R1 low half", v, 32'h0001_0000);
    rd(5, 1, v); chk(v == 32'h0, "R1 high half", v, 32'h0);
    chk(!mvalid, "R1 msg idle", {31'b0, mvalid}, 32'h0);
    none(4, "R1 no message");

    // R6 R10 R11 table walk of edge pins
    foreach (ROWS[r]) begin
      wr(ROWS[r].pin, 1, 32'(ROWS[r].dest) << 24);
      wr(ROWS[r].pin, 0, lo_word(ROWS[r].vec, ROWS[r].dlv, ROWS[r].dm, 1'b0, 1'b0));
      pulse(ROWS[r].pin);
      take(exp_addr(ROWS[r].dest, ROWS[r].dm), exp_data(ROWS[r].vec, ROWS[r].dlv, 1'b0),
           "R10 R11 table");
      none(6, "R6 single edge message");
    end

    // R12 backpressure hold
    pulse(1);
    @(negedge clk); @(negedge clk);
    a0 = maddr;
    repeat (5) @(negedge clk);
    chk(mvalid && maddr == a0 && mdata == exp_data(8'h31, 3'd0, 1'b0), "R12 hold",
        mdata, exp_data(8'h31, 3'd0, 1'b0));
    ready = 1; @(negedge clk); ready = 0;
    none(6, "R12 one outstanding");

    // R3 masked edge dropped
    wr(4, 0, lo_word(8'h44, 3'd0, 1'b0, 1'b0, 1'b1));
    pulse(4);
    none(6, "R3 masked edge");
    wr(4, 0, lo_word(8'h44, 3'd0, 1'b0, 1'b0, 1'b0));
    none(6, "R3 no leak on unmask");

    // R5 ascending order
    wr(3, 0, lo_word(8'h33, 3'd0, 1'b0, 1'b0, 1'b0));
    wr(6, 0, lo_word(8'h36, 3'd0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); irq[6] = 1; irq[3] = 1;
    @(negedge clk); irq[6] = 0; irq[3] = 0;
    take(32'hFEE0_0000, 32'h33, "R5 first lower pin");
    take(32'hFEE0_0000, 32'h36, "R5 second higher pin");

    // R7 R8 level remote-pending and EOI
    wr(9, 1, 32'h0200_0000);
    wr(9, 0, lo_word(8'h21, 3'd0, 1'b0, 1'b1, 1'b0));
    @(negedge clk); irq[9] = 1;
    take(32'hFEE0_2000, 32'h0000_8021, "R7 level delivery");
    rd(9, 0, v); chk(v == 32'h0000_c021, "R7 remote bit set", v, 32'h0000_c021);
    none(8, "R7 blocked while remote set");
    send_eoi(8'h22);
    none(6, "R8 wrong vector ignored");
    send_eoi(8'h21);
    take(32'hFEE0_2000, 32'h0000_8021, "R8 redelivery");
    @(negedge clk); irq[9] = 0;
    send_eoi(8'h21);
    none(6, "R4 low input cleared pending");
    rd(9, 0, v); chk(v == 32'h0000_8021, "R8 remote cleared", v, 32'h0000_8021);

    // R9 read-only bits and edge switch clears remote
    @(negedge clk); irq[9] = 1;
    take(32'hFEE0_2000, 32'h0000_8021, "R7 level again");
    @(negedge clk); irq[9] = 0;
    repeat (2) @(negedge clk);
    wr(9, 0, lo_word(8'h21, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(9, 0, v); chk(v == 32'h0001_0021, "R9 edge clears remote", v, 32'h0001_0021);
    wr(8, 0, 32'h0000_5040);
    rd(8, 0, v); chk(v == 32'h0000_0040, "R9 bits 12 14 read-only", v, 32'h0000_0040);
    none(4, "R9 no message");

    // R4 masked level delivered on unmask
    wr(12, 0, lo_word(8'h12, 3'd0, 1'b0, 1'b1, 1'b1));
    @(negedge clk); irq[12] = 1;
    none(6, "R4 masked level held");
    wr(12, 0, lo_word(8'h12, 3'd0, 1'b0, 1'b1, 1'b0));
    take(32'hFEE0_0000, 32'h0000_8012, "R4 unmask delivers");
    @(negedge clk); irq[12] = 0;
    send_eoi(8'h12);
    none(4, "R4 quiet after drop");

    // R2 input 0 routed to pin 2
    wr(2, 1, 32'h0);
    wr(2, 0, lo_word(8'h55, 3'd0, 1'b0, 1'b0, 1'b0));
    wr(0, 0, lo_word(8'h66, 3'd0, 1'b0, 1'b0, 1'b0));
    pulse(0);
    take(32'hFEE0_0000, 32'h0000_0055, "R2 input0 to pin2");
    none(6, "R2 pin0 never driven");

    // R13 rescan with nothing pending
    @(negedge clk); rescan = 1;
    @(negedge clk); rescan = 0;
    none(6, "R13 empty pass");

    summary();
    $finish;
  end
endmodule